// File: doc/BRIEF.md
# Multi-Counter Event Performance Monitor

This block holds ten event counters behind a simple register read/write port. Counter 0 advances on every clock. Counter 1 advances on every clock in which the retire input is high. Counters 2 to 9 each watch one line of an event bus, and an 8-bit selector per counter picks that line. A counter advances only when three things hold: its enable is set, the privilege-level filter allows the current level, and the core is in 64-bit execution state. A counter advances by at most 1 per cycle.

When an increment sets the counter's top bit, the block records an overflow status bit for that counter. If the interrupt for that counter is enabled, it also sets a sticky interrupt-active flag. A mode field sends the active flag to one of four output lines. An optional freeze bit stops all counting while the flag is set. Software clears the flag and the status bits by writing the registers.

Register map (address: content): 0 control, 1 privilege filter, 2 selectors for counters 2..5, 3 selectors for counters 6..9, 4 overflow status, 16+i counter i.

Top module: `evt_perfmon`

## Requirements
- R1: After reset, every counter and every register reads 0 and all four interrupt lines are low.
- R2: Counter 0 adds 1 on each counting cycle and counter 1 adds 1 on each counting cycle with `retire_i` high. The enable for counter i is control bit i for i<8 and bit 32+(i-8) for counters 8 and 9. When the enable is clear, the counter holds its value.
- R3: Counter 2+k (k=0..3) uses selector byte [8k+7:8k] of register 2, and counter 6+k uses the same byte of register 3. It adds 1 on cycles where `ev_bus_i[selector]` is high. A selector value of EVT_W or more never counts.
- R4: With `priv_i`=0 (user), counting requires filter bit 8+i (i<8) or 40+(i-8). With `priv_i`=1 (kernel), it requires filter bit 16+i or 48+(i-8). Any other level, or `exec_a64_i`=0, stops all counting.
- R5: A write to address 16+i loads `wdata_i[47:0]` into counter i at the next edge. The write takes priority over an increment in the same cycle.
- R6: An increment that moves bit 47 from 0 to 1 sets status bit i at the same edge. A counter at all ones wraps to 0. Status bits stay set until a write to address 4 replaces bits [9:0]. An overflow in the same cycle as that write still ends up set.
- R7: When control mode [10:8] is nonzero, an overflow on a counter whose interrupt enable is set sets control bit 11 at the same edge. The interrupt enable is control bit 12+i for i<8 and bit 44+(i-8) for counters 8 and 9. A control write with bit 11 = 0 clears the flag. A control write with bit 11 = 1 keeps the flag's value but never sets it.
- R8: While bit 11 is set, mode 1 drives `irq_pmi_o`, mode 2 drives `irq_ext_o`, mode 3 drives `halt_req_o` and mode 4 drives `irq_fiq_o`. Modes 0 and 5..7 drive no line. At most one line is high at a time.
- R9: While control bits 20 and 11 are both set, no counter increments. Counter writes still load.
- R10: `rdata_o` is a combinational read of the register at `addr_i`. Control reads back only bits [11:0], [20:12], [33:32] and [45:44]. The filter reads back only its defined bits. Selectors read back [31:0]. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for read and write |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data at `addr_i` |
| ev_bus_i | input | EVT_W | Event lines for the selectable counters |
| retire_i | input | 1 | Instruction retired this cycle |
| priv_i | input | 2 | Current privilege level (0 user, 1 kernel) |
| exec_a64_i | input | 1 | 1 when in 64-bit execution state |
| irq_pmi_o | output | 1 | Monitor interrupt line (mode 1) |
| irq_ext_o | output | 1 | External controller interrupt line (mode 2) |
| halt_req_o | output | 1 | Halt request (mode 3) |
| irq_fiq_o | output | 1 | Fast interrupt line (mode 4) |

## Verification
Every register, the status bits and the interrupt-active flag change at the clock edge that samples a write or an increment. Reads and interrupt lines are combinational, so every result is due one edge after its stimulus. The bench drives inputs just after a falling edge, and its reference model updates at the rising edge from the same sampled inputs. At the next falling edge the bench compares the read port and all four lines with the model. An overflow therefore shows in the status register, in control bit 11 and on the selected line one edge after the increment that crossed bit 47, and the bench checks all three at that point.

// File: rtl/evt_pm_pkg.sv
package evt_pm_pkg;
   localparam int unsigned N_CNT    = 10;
   localparam int unsigned SEL_W    = 8;
   localparam int unsigned DATA_W   = 64;

   localparam int unsigned A_CTRL   = 0;
   localparam int unsigned A_FILT   = 1;
   localparam int unsigned A_SEL_LO = 2;
   localparam int unsigned A_SEL_HI = 3;
   localparam int unsigned A_STAT   = 4;
   localparam int unsigned A_CNT0   = 16;

   localparam int unsigned ACT_BIT  = 11;
   localparam int unsigned FRZ_BIT  = 20;

   localparam logic [63:0] CFG_MASK  = 64'h0000_3003_001F_F7FF;
   localparam logic [63:0] FILT_MASK = 64'h0003_0300_00FF_FF00;

   typedef enum logic [2:0] {
      MODE_OFF  = 3'd0,
      MODE_PMI  = 3'd1,
      MODE_EXT  = 3'd2,
      MODE_HALT = 3'd3,
      MODE_FIQ  = 3'd4
   } irq_mode_e;

   function automatic int en_bit(input int i);
      return (i < 8) ? i : 24 + i;
   endfunction

   function automatic int irq_bit(input int i);
      return (i < 8) ? 12 + i : 36 + i;
   endfunction

   function automatic int usr_bit(input int i);
      return (i < 8) ? 8 + i : 32 + i;
   endfunction

   function automatic int krn_bit(input int i);
      return (i < 8) ? 16 + i : 40 + i;
   endfunction
endpackage

// File: rtl/evt_pm_evsel.sv
module evt_pm_evsel #(
   parameter int unsigned EVT_W = 64
) (
   input  logic [7:0]       sel_i,
   input  logic [EVT_W-1:0] ev_bus_i,
   output logic             hit_o
);
   localparam int unsigned IDX_W = (EVT_W > 1) ? $clog2(EVT_W) : 1;

   generate
      if (EVT_W >= 256) begin : g_full
         assign hit_o = ev_bus_i[sel_i];
      end else begin : g_range
         logic in_range;
         assign in_range = ({24'd0, sel_i} < EVT_W);
         assign hit_o    = in_range & ev_bus_i[sel_i[IDX_W-1:0]];
      end
   endgenerate
endmodule

// File: rtl/evt_pm_counter.sv
module evt_pm_counter #(
   parameter int unsigned W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] cnt_o,
   output logic         ovf_o
);
   localparam logic [W-1:0] EDGE_VAL = {1'b0, {(W-1){1'b1}}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (ld_i)  cnt_q <= ld_val_i;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
   end

   assign ovf_o = inc_i & ~ld_i & (cnt_q == EDGE_VAL);
   assign cnt_o = cnt_q;

   assert_ovf_sets_msb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> cnt_q[W-1]);
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !ld_i) |=> $stable(cnt_q));
   assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/evt_pm_regs.sv
module evt_pm_regs
   import evt_pm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_ctrl_i,
   input  logic                 wr_filt_i,
   input  logic                 wr_sel_lo_i,
   input  logic                 wr_sel_hi_i,
   input  logic                 wr_stat_i,
   input  logic [63:0]          wdata_i,
   input  logic [N_CNT-1:0]     ovf_i,
   output logic [63:0]          ctrl_o,
   output logic [63:0]          filt_o,
   output logic [31:0]          sel_lo_o,
   output logic [31:0]          sel_hi_o,
   output logic [N_CNT-1:0]     stat_o,
   output logic                 irq_pmi_o,
   output logic                 irq_ext_o,
   output logic                 halt_req_o,
   output logic                 irq_fiq_o
);
   logic [63:0]      cfg_q, filt_q;
   logic [31:0]      sel_lo_q, sel_hi_q;
   logic [N_CNT-1:0] stat_q, irq_en;
   logic             act_q, act_set;
   irq_mode_e        mode;

   always_comb begin
      for (int k = 0; k < int'(N_CNT); k++) irq_en[k] = cfg_q[irq_bit(k)];
   end

   assign mode    = irq_mode_e'(cfg_q[10:8]);
   assign act_set = (|(ovf_i & irq_en)) & (mode != MODE_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         filt_q   <= '0;
         sel_lo_q <= '0;
         sel_hi_q <= '0;
         stat_q   <= '0;
         act_q    <= 1'b0;
      end else begin
         if (wr_ctrl_i)   cfg_q    <= wdata_i & CFG_MASK;
         if (wr_filt_i)   filt_q   <= wdata_i & FILT_MASK;
         if (wr_sel_lo_i) sel_lo_q <= wdata_i[31:0];
         if (wr_sel_hi_i) sel_hi_q <= wdata_i[31:0];
         if (wr_stat_i)   stat_q   <= wdata_i[N_CNT-1:0] | ovf_i;
         else             stat_q   <= stat_q | ovf_i;
         if (wr_ctrl_i)   act_q    <= (act_q & wdata_i[ACT_BIT]) | act_set;
         else             act_q    <= act_q | act_set;
      end
   end

   always_comb begin
      irq_pmi_o  = 1'b0;
      irq_ext_o  = 1'b0;
      halt_req_o = 1'b0;
      irq_fiq_o  = 1'b0;
      if (act_q) begin
         case (mode)
            MODE_PMI:  irq_pmi_o  = 1'b1;
            MODE_EXT:  irq_ext_o  = 1'b1;
            MODE_HALT: halt_req_o = 1'b1;
            MODE_FIQ:  irq_fiq_o  = 1'b1;
            default:   ;
         endcase
      end
   end

   assign ctrl_o   = cfg_q | (64'(act_q) << ACT_BIT);
   assign filt_o   = filt_q;
   assign sel_lo_o = sel_lo_q;
   assign sel_hi_o = sel_hi_q;
   assign stat_o   = stat_q;

   assert_one_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_pmi_o, irq_ext_o, halt_req_o, irq_fiq_o}));
   assert_line_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pmi_o | irq_ext_o | halt_req_o | irq_fiq_o) |-> ctrl_o[ACT_BIT]);
   assert_stat_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
   assert_ovf_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|ovf_i) |=> ((stat_q & $past(ovf_i)) == $past(ovf_i)));
endmodule

// File: rtl/evt_perfmon.sv
module evt_perfmon
   import evt_pm_pkg::*;
#(
   parameter int unsigned CNT_W  = 48,
   parameter int unsigned EVT_W  = 64,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [63:0]       wdata_i,
   output logic [63:0]       rdata_o,
   input  logic [EVT_W-1:0]  ev_bus_i,
   input  logic              retire_i,
   input  logic [1:0]        priv_i,
   input  logic              exec_a64_i,
   output logic              irq_pmi_o,
   output logic              irq_ext_o,
   output logic              halt_req_o,
   output logic              irq_fiq_o
);
   localparam int unsigned TOP_ADDR = A_CNT0 + N_CNT - 1;

   initial begin
      if (CNT_W < 2 || CNT_W > 64) $fatal(1, "CNT_W must be 2..64");
      if (EVT_W < 2 || EVT_W > 256) $fatal(1, "EVT_W must be 2..256");
      if ((1 << ADDR_W) <= TOP_ADDR) $fatal(1, "ADDR_W too small for the map");
   end

   logic [63:0]      ctrl_q, filt_q;
   logic [31:0]      sel_lo_q, sel_hi_q;
   logic [N_CNT-1:0] stat_q, ovf_v, inc_v, wr_cnt;
   logic [CNT_W-1:0] cnt_q [N_CNT];
   logic             frozen;

   function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int unsigned target);
      return a == ADDR_W'(target);
   endfunction

   assign frozen = ctrl_q[FRZ_BIT] & ctrl_q[ACT_BIT];

   evt_pm_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ctrl_i   (wr_i & hit_addr(addr_i, A_CTRL)),
      .wr_filt_i   (wr_i & hit_addr(addr_i, A_FILT)),
      .wr_sel_lo_i (wr_i & hit_addr(addr_i, A_SEL_LO)),
      .wr_sel_hi_i (wr_i & hit_addr(addr_i, A_SEL_HI)),
      .wr_stat_i   (wr_i & hit_addr(addr_i, A_STAT)),
      .wdata_i     (wdata_i),
      .ovf_i       (ovf_v),
      .ctrl_o      (ctrl_q),
      .filt_o      (filt_q),
      .sel_lo_o    (sel_lo_q),
      .sel_hi_o    (sel_hi_q),
      .stat_o      (stat_q),
      .irq_pmi_o   (irq_pmi_o),
      .irq_ext_o   (irq_ext_o),
      .halt_req_o  (halt_req_o),
      .irq_fiq_o   (irq_fiq_o)
   );

   for (genvar i = 0; i < int'(N_CNT); i++) begin : g_cnt
      localparam int EN_B  = en_bit(i);
      localparam int USR_B = usr_bit(i);
      localparam int KRN_B = krn_bit(i);
      logic src, lvl_ok;

      if (i == 0) begin : g_cyc
         assign src = 1'b1;
      end else if (i == 1) begin : g_ret
         assign src = retire_i;
      end else begin : g_evt
         logic [7:0] sel;
         if (i < 6) begin : g_lo
            assign sel = sel_lo_q[8*(i-2) +: 8];
         end else begin : g_hi
            assign sel = sel_hi_q[8*(i-6) +: 8];
         end
         evt_pm_evsel #(.EVT_W(EVT_W)) u_sel (
            .sel_i    (sel),
            .ev_bus_i (ev_bus_i),
            .hit_o    (src)
         );
      end

      assign lvl_ok   = exec_a64_i & (((priv_i == 2'd0) & filt_q[USR_B]) |
                                      ((priv_i == 2'd1) & filt_q[KRN_B]));
      assign inc_v[i] = src & lvl_ok & ctrl_q[EN_B] & ~frozen;
      assign wr_cnt[i] = wr_i & hit_addr(addr_i, A_CNT0 + i);

      evt_pm_counter #(.W(CNT_W)) u_cnt (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc_i    (inc_v[i]),
         .ld_i     (wr_cnt[i]),
         .ld_val_i (wdata_i[CNT_W-1:0]),
         .cnt_o    (cnt_q[i]),
         .ovf_o    (ovf_v[i])
      );
   end

   always_comb begin
      rdata_o = '0;
      if (hit_addr(addr_i, A_CTRL))   rdata_o = ctrl_q;
      if (hit_addr(addr_i, A_FILT))   rdata_o = filt_q;
      if (hit_addr(addr_i, A_SEL_LO)) rdata_o = 64'(sel_lo_q);
      if (hit_addr(addr_i, A_SEL_HI)) rdata_o = 64'(sel_hi_q);
      if (hit_addr(addr_i, A_STAT))   rdata_o = 64'(stat_q);
      for (int k = 0; k < int'(N_CNT); k++) begin
         if (hit_addr(addr_i, A_CNT0 + k)) rdata_o = 64'(cnt_q[k]);
      end
   end

   assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[FRZ_BIT] && ctrl_q[ACT_BIT]) |-> (inc_v == '0));
   assert_no_count_off_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_a64_i || priv_i > 2'd1) |-> (inc_v == '0));
endmodule

// File: tb/evt_perfmon_tb_top.sv
module evt_perfmon_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;
   logic [63:0] ev_bus = '0;
   logic        retire = 1'b0;
   logic [1:0]  priv = 2'd0;
   logic        a64 = 1'b1;
   logic        pmi, ext, hlt, fiq;

   always #5 clk = ~clk;

   evt_perfmon dut_i (
      .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .ev_bus_i(ev_bus), .retire_i(retire), .priv_i(priv),
      .exec_a64_i(a64), .irq_pmi_o(pmi), .irq_ext_o(ext), .halt_req_o(hlt),
      .irq_fiq_o(fiq)
   );

   localparam logic [63:0] M48 = 64'h0000_FFFF_FFFF_FFFF;
   int          n_run = 0, n_fail = 0;
   bit          done = 0;
   string       cur = "R1";
   logic [63:0] m_cfg = '0, m_filt = '0, m_cnt [10];
   logic [31:0] m_sel [2];
   logic [9:0]  m_stat = '0;
   logic        m_act = 1'b0;

   initial begin
      for (int i = 0; i < 10; i++) m_cnt[i] = '0;
      m_sel[0] = '0;
      m_sel[1] = '0;
   end

   // reference model, behavioural, updated from the inputs sampled at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = '0; m_filt = '0; m_stat = '0; m_act = 0;
         m_sel[0] = '0; m_sel[1] = '0;
         for (int i = 0; i < 10; i++) m_cnt[i] = '0;
      end else begin
         logic [9:0] ov;
         logic frz, en, ok, src, set;
         int sel, ub, kb, eb, ib;
         ov  = '0;
         set = 0;
         frz = m_cfg[20] & m_act;
         for (int i = 0; i < 10; i++) begin
            eb = (i < 8) ? i : 32 + i - 8;
            ub = (i < 8) ? 8 + i : 40 + i - 8;
            kb = (i < 8) ? 16 + i : 48 + i - 8;
            ib = (i < 8) ? 12 + i : 44 + i - 8;
            en = m_cfg[eb];
            ok = a64 && ((priv == 0 && m_filt[ub]) || (priv == 1 && m_filt[kb]));
            if (i == 0) src = 1;
            else if (i == 1) src = retire;
            else begin
               sel = (i < 6) ? int'(m_sel[0][8*(i-2) +: 8]) : int'(m_sel[1][8*(i-6) +: 8]);
               src = (sel < 64) ? ev_bus[sel] : 1'b0;
            end
            if (wr && addr == 5'(16 + i)) m_cnt[i] = wdata & M48;
            else if (en && ok && src && !frz) begin
               if (m_cnt[i] == 64'h0000_7FFF_FFFF_FFFF) begin
                  ov[i] = 1;
                  if (m_cfg[ib] && m_cfg[10:8] != 0) set = 1;
               end
               m_cnt[i] = (m_cnt[i] + 1) & M48;
            end
         end
         if (wr && addr == 5'd4) m_stat = wdata[9:0] | ov;
         else m_stat = m_stat | ov;
         if (wr && addr == 5'd0) begin
            m_act = (m_act & wdata[11]) | set;
            m_cfg = wdata & 64'h0000_3003_001F_F7FF;
         end else m_act = m_act | set;
         if (wr && addr == 5'd1) m_filt = wdata & 64'h0003_0300_00FF_FF00;
         if (wr && addr == 5'd2) m_sel[0] = wdata[31:0];
         if (wr && addr == 5'd3) m_sel[1] = wdata[31:0];
      end
   end

   function automatic logic [63:0] model_read(input logic [4:0] a);
      if (a == 0) return m_cfg | (64'(m_act) << 11);
      if (a == 1) return m_filt;
      if (a == 2) return 64'(m_sel[0]);
      if (a == 3) return 64'(m_sel[1]);
      if (a == 4) return 64'(m_stat);
      if (a >= 16 && a < 26) return m_cnt[a - 16];
      return '0;
   endfunction

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      logic [3:0] lines;
      lines = '0;
      if (m_act) begin
         if (m_cfg[10:8] == 3'd1) lines[0] = 1;   // R8 mode 1
         if (m_cfg[10:8] == 3'd2) lines[1] = 1;   // R8 mode 2
         if (m_cfg[10:8] == 3'd3) lines[2] = 1;   // R8 mode 3
         if (m_cfg[10:8] == 3'd4) lines[3] = 1;   // R8 mode 4
      end
      check(cur, $sformatf("rdata@%0d", addr), rdata, model_read(addr));
      check(cur, "lines", 64'({fiq, hlt, ext, pmi}), 64'(lines));
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         compare();
         ev_bus = {$urandom, $urandom};
         retire = 1'($urandom);
      end
   endtask

   task automatic wr_reg(input logic [4:0] a, input logic [63:0] d);
      wr = 1; addr = a; wdata = d;
      step(1);
      wr = 0;
   endtask

   initial begin
      // R1: reset values of every register and line
      @(posedge clk);
      @(negedge clk);
      for (int a = 0; a < 26; a++) begin
         if (a < 5 || a >= 16) begin
            addr = 5'(a);
            step(1);
         end
      end
      rst_n = 1;
      step(1);

      // R10: masked readback, unmapped addresses; R7: writing bit 11 = 1 never sets the flag
      cur = "R10";
      wr_reg(0, 64'hFFFF_FFFF_FFFF_FFFF); addr = 0; step(1);
      wr_reg(1, 64'hFFFF_FFFF_FFFF_FFFF); addr = 1; step(1);
      wr_reg(5, 64'h1234); addr = 5; step(1);
      addr = 15; step(1); addr = 26; step(1); addr = 31; step(1);
      wr_reg(0, 0); wr_reg(1, 0);

      // R2: fixed cycle and retire counters, then disabled
      cur = "R2";
      wr_reg(1, 64'h0000_0300_0000_FF00);
      wr_reg(0, 64'h3);
      addr = 16; step(10); addr = 17; step(10);
      wr_reg(0, 0); addr = 17; step(5); addr = 16; step(3);

      // R3: selectable counters, including an out-of-range selector
      cur = "R3";
      wr_reg(2, 64'h0500_C805);
      wr_reg(3, 64'h3F03_0201);
      wr_reg(0, 64'h0000_0003_0000_00FF);
      addr = 2; step(1); addr = 3; step(1);
      for (int a = 18; a < 26; a++) begin
         addr = 5'(a);
         step(4);
      end

      // R4: privilege and execution-state filter
      cur = "R4";
      priv = 1; addr = 18; step(4);
      wr_reg(1, 64'h0003_0000_00FF_0000); addr = 24; step(4);
      priv = 2; addr = 16; step(3);
      priv = 1; a64 = 0; addr = 25; step(3);
      a64 = 1; step(3);

      // R5: a counter write wins over an increment in the same cycle
      cur = "R5";
      wr_reg(18, 64'hFFFF_1234_5678_9ABC); addr = 18; step(3);
      wr_reg(16, 64'h42); addr = 16; step(2);

      // R6/R7/R8: overflow on counter 0 with interrupt mode 1, then sweep the modes
      cur = "R7";
      wr_reg(0, 64'h0000_0000_0000_1101);
      wr_reg(16, 64'h0000_7FFF_FFFF_FFFD);
      addr = 4; step(4); addr = 0; step(2);
      cur = "R8";
      for (int m = 2; m < 8; m++) begin
         wr_reg(0, 64'h1801 | (64'(m) << 8));
         addr = 0; step(2);
      end
      cur = "R6";
      wr_reg(4, 0); addr = 4; step(2);
      wr_reg(0, 64'h1101); addr = 0; step(2);
      wr_reg(16, 64'h0000_FFFF_FFFF_FFFE); addr = 16; step(4);

      // R9: freeze on an active interrupt
      cur = "R9";
      wr_reg(1, 64'h0000_0300_0000_FF00);
      priv = 0;
      wr_reg(0, 64'h0010_1103);
      wr_reg(16, 64'h0000_7FFF_FFFF_FFFE);
      addr = 17; step(6); addr = 16; step(3);
      wr_reg(17, 64'h77); addr = 17; step(2);
      wr_reg(0, 64'h3); addr = 16; step(3);

      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule